// File: doc/BRIEF.md
# Unlock-Protected Flash Command Decoder

This block is the synchronous command front end of a byte-wide flash bank whose contents are shielded by an unlock protocol. It watches single-cycle bus writes, each with a 19-bit address and a data byte. It recognises the keyed sequences for byte program, sector erase, full-bank erase and entry to or exit from the identification mode. When a program or erase sequence completes, it sends one start pulse to the internal program/erase timer. The pulse carries the latched operation type, address and data.

A write counts only in a cycle where the bank enable is low, the write enable is low and the output enable is high. There is no back-pressure: the bus has no ready signal, and a qualified write is consumed in the cycle it appears. While the timer raises `busy`, every write is dropped and the decoder state is frozen. Reads pass the array data through unchanged, except in identification mode, where the two identity bytes are returned.

Top module: `fcmd_decoder`

## Requirements
- R1: After a synchronous reset, `start` is 0, `id_mode` is 0, the decoder waits for a fresh sequence, and `rd_data` equals `array_rdata`.
- R2: A write is qualified only in a cycle with `bank_en_n`=0, `wr_en_n`=0 and `out_en_n`=1. A cycle with `out_en_n`=0 or `bank_en_n`=1 is not a write and leaves the sequence position unchanged.
- R3: Byte program takes four writes: AAh at 5555h, 55h at 2AAAh, A0h at 5555h, then a fourth write at any address. In the cycle after the fourth write, `start` is 1, `op`=1, and `op_addr`/`op_data` equal the address and data of the fourth write.
- R4: Sector erase takes six writes: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at any address. It gives `op`=2, `op_data`=FFh, and `op_addr` equal to the final address with bits 11..0 cleared. Bits 18..12 of that address name the sector.
- R5: Bank erase is the same as R4, except that the final write is 10h at exactly 5555h. It gives `op`=3, `op_addr`=0 and `op_data`=FFh. A final 10h at any other address starts nothing.
- R6: A qualified write that does not match the next expected step returns the decoder to idle. The step is not retried, so a later partial sequence does not complete, but a complete new sequence is then accepted.
- R7: While `busy`=1, all writes are ignored, including identification entry and exit. No `start` is produced and `id_mode` does not change.
- R8: AAh@5555h, 55h@2AAAh, 90h@5555h sets `id_mode`. In that mode, reading address 0 gives BFh, address 1 gives the `DEV_CODE` parameter (default 65h), and any other address gives 00h.
- R9: AAh@5555h, 55h@2AAAh, F0h@5555h clears `id_mode`, and `rd_data` again follows `array_rdata`.
- R10: `start` lasts exactly one cycle. `op`, `op_addr` and `op_data` keep their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_en_n | input | 1 | Flash bank enable, active low |
| wr_en_n | input | 1 | Write enable, active low |
| out_en_n | input | 1 | Output enable, active low |
| addr | input | 19 | Bus address, used by writes and reads |
| wdata | input | 8 | Write data byte |
| busy | input | 1 | Program/erase timer is running |
| array_rdata | input | 8 | Read data from the array |
| rd_data | output | 8 | Read data returned to the bus |
| id_mode | output | 1 | Identification mode active |
| start | output | 1 | One-cycle launch of the program/erase timer |
| op | output | 2 | Operation: 1 program, 2 sector erase, 3 bank erase |
| op_addr | output | 19 | Latched target address |
| op_data | output | 8 | Latched program byte, or FFh for erase |

## Verification
The bench targets the following corner cases:
- An abort followed by the rest of a sequence. A decoder that does not really return to idle would launch a program from the leftover writes.
- A final erase write of 10h at the wrong address. This would be treated as a bank erase if the address were not compared.
- A fourth program write that is made unqualified by a low output enable. A decoder that ignores the strobe qualification would program the wrong byte.
- Identification entry and exit issued while busy. A decoder that lets them through would change the read mux in the middle of an operation.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PROG = 2'd1,
    OP_SECT = 2'd2,
    OP_BANK = 2'd3
  } fop_t;

  typedef enum logic [2:0] {
    S_IDLE, S_U1, S_U2, S_PGM, S_E1, S_E2, S_E3
  } fseq_t;

  localparam logic [15:0] KEY_ADDR_A = 16'h5555;
  localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  KEY_AA     = 8'hAA;
  localparam logic [7:0]  KEY_55     = 8'h55;
  localparam logic [7:0]  CMD_PROG   = 8'hA0;
  localparam logic [7:0]  CMD_ERASE  = 8'h80;
  localparam logic [7:0]  CMD_IDIN   = 8'h90;
  localparam logic [7:0]  CMD_IDOUT  = 8'hF0;
  localparam logic [7:0]  CMD_SECT   = 8'h30;
  localparam logic [7:0]  CMD_BANK   = 8'h10;
  localparam logic [7:0]  MFR_BYTE   = 8'hBF;
endpackage

// File: rtl/fcmd_seq.sv
module fcmd_seq
  import fcmd_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 8,
  parameter int SECT_LSB = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ok_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              launch_o,
  output fop_t              launch_op_o,
  output logic [ADDR_W-1:0] launch_addr_o,
  output logic [DATA_W-1:0] launch_data_o,
  output logic              id_set_o,
  output logic              id_clr_o
);
  localparam int SECT_W = ADDR_W - SECT_LSB;

  fseq_t state_q, state_d;
  logic  at_a, at_b;

  assign at_a = (addr_i == ADDR_W'(KEY_ADDR_A));
  assign at_b = (addr_i == ADDR_W'(KEY_ADDR_B));

  always_comb begin
    state_d       = state_q;
    launch_o      = 1'b0;
    launch_op_o   = OP_NONE;
    launch_addr_o = '0;
    launch_data_o = '1;
    id_set_o      = 1'b0;
    id_clr_o      = 1'b0;
    if (wr_ok_i) begin
      state_d = S_IDLE;
      case (state_q)
        S_IDLE: if (at_a && data_i == KEY_AA) state_d = S_U1;
        S_U1:   if (at_b && data_i == KEY_55) state_d = S_U2;
        S_U2: begin
          if (at_a) begin
            case (data_i)
              CMD_PROG:  state_d = S_PGM;
              CMD_ERASE: state_d = S_E1;
              CMD_IDIN:  id_set_o = 1'b1;
              CMD_IDOUT: id_clr_o = 1'b1;
              default:   state_d = S_IDLE;
            endcase
          end
        end
        S_PGM: begin
          launch_o      = 1'b1;
          launch_op_o   = OP_PROG;
          launch_addr_o = addr_i;
          launch_data_o = data_i;
        end
        S_E1: if (at_a && data_i == KEY_AA) state_d = S_E2;
        S_E2: if (at_b && data_i == KEY_55) state_d = S_E3;
        S_E3: begin
          if (data_i == CMD_SECT) begin
            launch_o      = 1'b1;
            launch_op_o   = OP_SECT;
            launch_addr_o = {addr_i[ADDR_W-1:SECT_LSB], SECT_LSB'(0)};
          end else if (data_i == CMD_BANK && at_a) begin
            launch_o    = 1'b1;
            launch_op_o = OP_BANK;
          end
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_IDLE;
    else     state_q <= state_d;
  end

  // R6: after any launch the sequence restarts from idle
  assert_idle_after_launch_R6: assert property (@(posedge clk) disable iff (rst)
    launch_o |=> state_q == S_IDLE);

  // R7: without a qualified write the sequence position holds
  assert_hold_no_write_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_ok_i |=> $stable(state_q));

  // R4: a sector launch carries a sector-aligned address
  assert_sector_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    (launch_o && launch_op_o == OP_SECT) |->
      launch_addr_o[SECT_LSB-1:0] == '0 && SECT_W > 0);
endmodule

// File: rtl/fcmd_launch.sv
module fcmd_launch
  import fcmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch_i,
  input  fop_t              op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              start_o,
  output fop_t              op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      start_o <= 1'b0;
      op_o    <= OP_NONE;
      addr_o  <= '0;
      data_o  <= '0;
    end else begin
      start_o <= launch_i;
      if (launch_i) begin
        op_o   <= op_i;
        addr_o <= addr_i;
        data_o <= data_i;
      end
    end
  end

  // R10: start never lasts two cycles
  assert_start_single_R10: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);

  // R10: operation fields hold between launches
  assert_fields_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !launch_i |=> $stable(op_o) && $stable(addr_o) && $stable(data_o));

  // R3: a start always names a real operation
  assert_start_has_op_R3: assert property (@(posedge clk) disable iff (rst)
    start_o |-> op_o != OP_NONE);
endmodule

// File: rtl/fcmd_idread.sv
module fcmd_idread
  import fcmd_pkg::*;
#(
  parameter int          ADDR_W   = 19,
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  DEV_CODE = 8'h65
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] array_i,
  output logic              id_mode_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic id_q;

  always_ff @(posedge clk) begin
    if (rst)        id_q <= 1'b0;
    else if (set_i) id_q <= 1'b1;
    else if (clr_i) id_q <= 1'b0;
  end

  always_comb begin
    if (!id_q)                        rd_data_o = array_i;
    else if (addr_i == ADDR_W'(0))    rd_data_o = DATA_W'(MFR_BYTE);
    else if (addr_i == ADDR_W'(1))    rd_data_o = DATA_W'(DEV_CODE);
    else                              rd_data_o = '0;
  end

  assign id_mode_o = id_q;

  // R8/R9: the mode changes only on a decoded entry or exit command
  assert_id_change_cmd_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(id_q) |-> $past(set_i || clr_i));
endmodule

// File: rtl/fcmd_decoder.sv
module fcmd_decoder
  import fcmd_pkg::*;
#(
  parameter int         ADDR_W   = 19,
  parameter int         DATA_W   = 8,
  parameter int         SECT_LSB = 12,
  parameter logic [7:0] DEV_CODE = 8'h65
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bank_en_n,
  input  logic              wr_en_n,
  input  logic              out_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic [DATA_W-1:0] array_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              id_mode,
  output logic              start,
  output logic [1:0]        op,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data
);
  logic              wr_ok, launch, id_set, id_clr;
  fop_t              l_op, r_op;
  logic [ADDR_W-1:0] l_addr;
  logic [DATA_W-1:0] l_data;

  assign wr_ok = !bank_en_n && !wr_en_n && out_en_n && !busy;

  fcmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_LSB(SECT_LSB)) seq_i (
    .clk(clk), .rst(rst), .wr_ok_i(wr_ok), .addr_i(addr), .data_i(wdata),
    .launch_o(launch), .launch_op_o(l_op), .launch_addr_o(l_addr),
    .launch_data_o(l_data), .id_set_o(id_set), .id_clr_o(id_clr)
  );

  fcmd_launch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) launch_i (
    .clk(clk), .rst(rst), .launch_i(launch), .op_i(l_op), .addr_i(l_addr),
    .data_i(l_data), .start_o(start), .op_o(r_op), .addr_o(op_addr),
    .data_o(op_data)
  );

  fcmd_idread #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_CODE(DEV_CODE)) idrd_i (
    .clk(clk), .rst(rst), .set_i(id_set), .clr_i(id_clr), .addr_i(addr),
    .array_i(array_rdata), .id_mode_o(id_mode), .rd_data_o(rd_data)
  );

  assign op = r_op;

  // R7: a busy cycle can never be followed by a start
  assert_no_start_busy_R7: assert property (@(posedge clk) disable iff (rst)
    busy |=> !start);

  // R2: an inhibited bus cycle cannot lead to a start
  assert_inhibit_no_start_R2: assert property (@(posedge clk) disable iff (rst)
    (!out_en_n || bank_en_n) |=> !start);

  // R4: sector erase output is sector aligned
  assert_sect_addr_R4: assert property (@(posedge clk) disable iff (rst)
    (start && op == 2'd2) |-> op_addr[SECT_LSB-1:0] == '0);
endmodule

// File: tb/fcmd_decoder_tb.sv
module fcmd_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bank_en_n = 1'b1, wr_en_n = 1'b1, out_en_n = 1'b1;
  logic [18:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        busy = 1'b0;
  logic [7:0]  array_rdata = 8'h5A;
  logic [7:0]  rd_data;
  logic        id_mode, start;
  logic [1:0]  op;
  logic [18:0] op_addr;
  logic [7:0]  op_data;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  fcmd_decoder dut_i (
    .clk(clk), .rst(rst), .bank_en_n(bank_en_n), .wr_en_n(wr_en_n),
    .out_en_n(out_en_n), .addr(addr), .wdata(wdata), .busy(busy),
    .array_rdata(array_rdata), .rd_data(rd_data), .id_mode(id_mode),
    .start(start), .op(op), .op_addr(op_addr), .op_data(op_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d,
                    input logic ben = 1'b0, input logic oen = 1'b1);
    @(negedge clk);
    addr = a; wdata = d; bank_en_n = ben; wr_en_n = 1'b0; out_en_n = oen;
    @(negedge clk);
    bank_en_n = 1'b1; wr_en_n = 1'b1; out_en_n = 1'b1;
  endtask

  task automatic unlock3(input logic [7:0] cmd);
    wr(19'h05555, 8'hAA);
    wr(19'h02AAA, 8'h55);
    wr(19'h05555, cmd);
  endtask

  task automatic erase5();
    unlock3(8'h80);
    wr(19'h05555, 8'hAA);
    wr(19'h02AAA, 8'h55);
  endtask

  task automatic idle_cycle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 start", start, 0);
    chk("R1 id_mode", id_mode, 0);
    chk("R1 rd_data", rd_data, 8'h5A);
  endtask

  task automatic t_program();
    unlock3(8'hA0);
    wr(19'h12345, 8'h3C);
    chk("R3 start", start, 1);
    chk("R3 op", op, 1);
    chk("R3 op_addr", op_addr, 19'h12345);
    chk("R3 op_data", op_data, 8'h3C);
    idle_cycle();
    chk("R10 start drop", start, 0);
    chk("R10 op_addr hold", op_addr, 19'h12345);
    chk("R10 op_data hold", op_data, 8'h3C);
  endtask

  task automatic t_sector();
    erase5();
    wr(19'h7F123, 8'h30);
    chk("R4 start", start, 1);
    chk("R4 op", op, 2);
    chk("R4 op_addr", op_addr, 19'h7F000);
    chk("R4 op_data", op_data, 8'hFF);
    idle_cycle();
  endtask

  task automatic t_bank();
    erase5();
    wr(19'h01234, 8'h10);
    chk("R5 wrong addr no start", start, 0);
    idle_cycle();
    chk("R5 wrong addr held op", op, 2);
    erase5();
    wr(19'h05555, 8'h10);
    chk("R5 start", start, 1);
    chk("R5 op", op, 3);
    chk("R5 op_addr", op_addr, 0);
    chk("R5 op_data", op_data, 8'hFF);
    idle_cycle();
  endtask

  task automatic t_abort();
    wr(19'h05555, 8'hAA);
    wr(19'h01111, 8'h55);
    wr(19'h05555, 8'hA0);
    wr(19'h00100, 8'h77);
    chk("R6 abort no start", start, 0);
    erase5();
    wr(19'h02AAA, 8'h77);
    wr(19'h05555, 8'h10);
    chk("R6 erase abort no start", start, 0);
    unlock3(8'hA0);
    wr(19'h00200, 8'h11);
    chk("R6 recover start", start, 1);
    chk("R6 recover addr", op_addr, 19'h00200);
    idle_cycle();
  endtask

  task automatic t_qualify();
    unlock3(8'hA0);
    wr(19'h00300, 8'h99, 1'b0, 1'b0);
    chk("R2 oe low no start", start, 0);
    wr(19'h00400, 8'h98, 1'b1, 1'b1);
    chk("R2 bank off no start", start, 0);
    wr(19'h00500, 8'h42);
    chk("R2 qualified start", start, 1);
    chk("R2 data of qualified", op_data, 8'h42);
    idle_cycle();
  endtask

  task automatic t_busy();
    @(negedge clk); busy = 1'b1;
    unlock3(8'hA0);
    wr(19'h00600, 8'h24);
    chk("R7 busy no start", start, 0);
    unlock3(8'h90);
    chk("R7 busy no id entry", id_mode, 0);
    chk("R7 busy op held", op_addr, 19'h00500);
    @(negedge clk); busy = 1'b0;
  endtask

  task automatic t_id();
    unlock3(8'h90);
    chk("R8 id_mode set", id_mode, 1);
    addr = 19'h0; #1;
    chk("R8 mfr byte", rd_data, 8'hBF);
    addr = 19'h1; #1;
    chk("R8 dev byte", rd_data, 8'h65);
    addr = 19'h2; #1;
    chk("R8 other byte", rd_data, 8'h00);
    @(negedge clk); busy = 1'b1;
    unlock3(8'hF0);
    chk("R7 busy no id exit", id_mode, 1);
    @(negedge clk); busy = 1'b0;
    unlock3(8'hF0);
    chk("R9 id_mode clear", id_mode, 0);
    addr = 19'h0; #1;
    chk("R9 array pass", rd_data, 8'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_program();
    t_sector();
    t_bank();
    t_abort();
    t_qualify();
    t_busy();
    t_id();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule